// File: doc/BRIEF.md
# Segment Descriptor Fetch Sequencer

This block fetches a segment descriptor from memory when an operand store cannot be served by the descriptor cache. A miss, or an explicit request to go around the cache, starts the walk. The descriptor segment can be paged or unpaged, and a flag in the descriptor-base input selects which.

In paged mode the block first reads the page-table entry that maps the part of the descriptor segment holding the requested segment. It faults if that entry is marked absent. If the entry's used flag is clear, it writes the entry back with that flag set. It then reads the two-word descriptor from the mapped page. In unpaged mode it reads the two descriptor words straight from the base address. A descriptor that is marked absent raises a directed fault. A good descriptor is offered to the cache together with the bypass flag of the request.

Memory is a single request/acknowledge port. A request holds its address, direction and write data until the acknowledge. Read data is valid in the cycle the acknowledge is high. The segment number, base, mode and bypass flag are captured when a walk starts.

Top module: `seg_desc_fetch`

## Requirements
- R1: A walk starts only when `start` is high while the block is idle and either `cam_hit` is low or `bypass` is high. With `cam_hit` high and `bypass` low the block stays idle, raises no `busy`, and issues no memory request.
- R2: In paged mode (`dbr_unpaged` = 0) the first access is a read at `dbr_base + ((2*seg) >> 10)`.
- R3: A page-table entry whose bit 3 (present) is 0 ends the walk with a fault whose number is 16 plus entry bits [2:0]. No further memory access and no cache load follow.
- R4: A present page-table entry whose bit 4 (used) is 0 is written back to the same address with bit 4 set, before any descriptor read. An entry with bit 4 set causes no write. Every write carries bit 4 set.
- R5: In paged mode the descriptor is read at `{entry[35:22], (2*seg)[9:0]}` and then at that address plus 1.
- R6: In unpaged mode the descriptor is read at `dbr_base + 2*seg` and `dbr_base + 2*seg + 1`, with no page-table access.
- R7: The second descriptor read is requested in the cycle right after the first read is acknowledged.
- R8: A descriptor whose word 0 bit 3 is 0 ends the walk with a fault numbered 16 plus word 0 bits [2:0], and with no cache load.
- R9: A good descriptor produces a one-cycle `ld_valid` together with `done`. The load carries the captured segment number, both words and the captured bypass flag.
- R10: `fault` is high for exactly one cycle per faulting walk, never together with `done`. `fault_num` is 0 whenever `fault` is low.
- R11: Reset, including reset in the middle of a walk, returns the block to idle with `mem_req` and `busy` low.
- R12: A page-table entry with both bit 3 and bit 4 at 0 faults (R3) and is not written back.
- R13: While a request waits for its acknowledge, its address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operand store needs a descriptor |
| seg_num | input | 15 | Segment number to translate |
| cam_hit | input | 1 | Descriptor cache holds this segment |
| bypass | input | 1 | Ignore the cache and walk anyway |
| dbr_unpaged | input | 1 | Descriptor segment is unpaged |
| dbr_base | input | 24 | Descriptor segment or page-table base address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 24 | Request address |
| mem_wdata | output | 36 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 36 | Read data |
| ld_valid | output | 1 | Load descriptor into cache |
| ld_seg | output | 15 | Segment number of the load |
| ld_word0 | output | 36 | Descriptor word 0 |
| ld_word1 | output | 36 | Descriptor word 1 |
| ld_bypass | output | 1 | Bypass flag passed with the load |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished successfully (one cycle) |
| fault | output | 1 | Directed fault (one cycle) |
| fault_num | output | 5 | Fault number while `fault` is high |

## Verification
Two decisions can arise from the same page-table entry in the same cycle: the absent fault and the used-flag writeback. The bench hands the block an entry with both flags at zero. A correct block shows one fault pulse with the entry's code and logs no write cycle on the memory port.

A second overlap arises when a cache hit and a bypass request arrive together. The bench checks that the walk still runs and that the load carries the bypass flag.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int FNUM_W   = 5;
  localparam int FC_W     = 3;
  localparam int DF_BIT   = 3;
  localparam int USED_BIT = 4;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PTW_RD,
    S_PTW_CHK,
    S_PTW_WB,
    S_SDW_RD0,
    S_SDW_RD1,
    S_SDW_CHK,
    S_FAULT,
    S_DONE
  } sdf_state_t;
endpackage

// File: rtl/sdf_rst_sync.sv
module sdf_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/sdf_addr_gen.sv
module sdf_addr_gen #(
  parameter int SEG_W  = 15,
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 10
) (
  input  logic [SEG_W-1:0]         seg,
  input  logic [ADDR_W-1:0]        base,
  input  logic                     unpaged,
  input  logic [ADDR_W-PAGE_W-1:0] frame,
  output logic [ADDR_W-1:0]        ptw_addr,
  output logic [ADDR_W-1:0]        desc_addr
);
  localparam int OFF_W = SEG_W + 1;

  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] paged_addr;

  // each descriptor occupies two words
  assign off_ext    = {{(ADDR_W-OFF_W){1'b0}}, seg, 1'b0};
  assign ptw_addr   = base + (off_ext >> PAGE_W);
  assign paged_addr = {frame, off_ext[PAGE_W-1:0]};
  assign desc_addr  = unpaged ? (base + off_ext) : paged_addr;
endmodule

// File: rtl/sdf_ctl.sv
module sdf_ctl
  import sdf_pkg::*;
#(
  parameter int SEG_W   = 15,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 36,
  parameter int FRAME_W = 14,
  parameter logic [FNUM_W-1:0] DF_BASE = 5'd16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cam_hit,
  input  logic                bypass,
  input  logic [SEG_W-1:0]    seg_in,
  input  logic [ADDR_W-1:0]   base_in,
  input  logic                unpaged_in,
  input  logic [ADDR_W-1:0]   ptw_addr,
  input  logic [ADDR_W-1:0]   desc_addr,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [SEG_W-1:0]    seg_q,
  output logic [ADDR_W-1:0]   base_q,
  output logic                unpaged_q,
  output logic                bypass_q,
  output logic [FRAME_W-1:0]  frame,
  output logic [DATA_W-1:0]   w0_q,
  output logic [DATA_W-1:0]   w1_q,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                busy,
  output logic                done,
  output logic                fault,
  output logic [FNUM_W-1:0]   fault_num
);
  sdf_state_t         st_q, st_d;
  logic [DATA_W-1:0]  ptw_q;
  logic [FNUM_W-1:0]  fnum_q, fnum_d;
  logic [FC_W-1:0]    fc_sel;
  logic               accept, ptw_en, w0_en, w1_en, fnum_en;

  assign accept  = (st_q == S_IDLE) && start && (!cam_hit || bypass);
  assign ptw_en  = (st_q == S_PTW_RD)  && mem_ack;
  assign w0_en   = (st_q == S_SDW_RD0) && mem_ack;
  assign w1_en   = (st_q == S_SDW_RD1) && mem_ack;
  assign fnum_en = (st_d == S_FAULT) && (st_q != S_FAULT);

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:    if (accept) st_d = unpaged_in ? S_SDW_RD0 : S_PTW_RD;
      S_PTW_RD:  if (mem_ack) st_d = S_PTW_CHK;
      S_PTW_CHK: begin
        // absence outranks the used-flag update
        if (!ptw_q[DF_BIT])        st_d = S_FAULT;
        else if (!ptw_q[USED_BIT]) st_d = S_PTW_WB;
        else                       st_d = S_SDW_RD0;
      end
      S_PTW_WB:  if (mem_ack) st_d = S_SDW_RD0;
      S_SDW_RD0: if (mem_ack) st_d = S_SDW_RD1;
      S_SDW_RD1: if (mem_ack) st_d = S_SDW_CHK;
      S_SDW_CHK: st_d = w0_q[DF_BIT] ? S_DONE : S_FAULT;
      S_FAULT:   st_d = S_IDLE;
      S_DONE:    st_d = S_IDLE;
      default:   st_d = S_IDLE;
    endcase
  end

  assign fc_sel = (st_q == S_PTW_CHK) ? ptw_q[FC_W-1:0] : w0_q[FC_W-1:0];
  assign fnum_d = DF_BASE + {{(FNUM_W-FC_W){1'b0}}, fc_sel};

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      fnum_q <= '0;
    end else begin
      st_q <= st_d;
      if (fnum_en) fnum_q <= fnum_d;
    end
  end

  // data registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      seg_q     <= seg_in;
      base_q    <= base_in;
      unpaged_q <= unpaged_in;
      bypass_q  <= bypass;
    end
    if (ptw_en) ptw_q <= mem_rdata;
    if (w0_en)  w0_q  <= mem_rdata;
    if (w1_en)  w1_q  <= mem_rdata;
  end

  assign frame = ptw_q[DATA_W-1 -: FRAME_W];

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st_q)
      S_PTW_RD: begin
        mem_req  = 1'b1;
        mem_addr = ptw_addr;
      end
      S_PTW_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptw_addr;
        mem_wdata = ptw_q | (DATA_W'(1) << USED_BIT);
      end
      S_SDW_RD0: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr;
      end
      S_SDW_RD1: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + ADDR_W'(1);
      end
      default: ;
    endcase
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_DONE);
  assign fault     = (st_q == S_FAULT);
  assign fault_num = fault ? fnum_q : '0;
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import sdf_pkg::*;
#(
  parameter int SEG_W  = 15,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 36,
  parameter int PAGE_W = 10,
  parameter logic [FNUM_W-1:0] DF_BASE = 5'd16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEG_W-1:0]  seg_num,
  input  logic              cam_hit,
  input  logic              bypass,
  input  logic              dbr_unpaged,
  input  logic [ADDR_W-1:0] dbr_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [SEG_W-1:0]  ld_seg,
  output logic [DATA_W-1:0] ld_word0,
  output logic [DATA_W-1:0] ld_word1,
  output logic              ld_bypass,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [FNUM_W-1:0] fault_num
);
  localparam int FRAME_W = ADDR_W - PAGE_W;

  logic              rst_n_s;
  logic [SEG_W-1:0]  seg_q;
  logic [ADDR_W-1:0] base_q;
  logic              unpaged_q;
  logic [FRAME_W-1:0] frame;
  logic [ADDR_W-1:0] ptw_addr, desc_addr;

  sdf_rst_sync rst_i (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  sdf_addr_gen #(
    .SEG_W (SEG_W), .ADDR_W (ADDR_W), .PAGE_W (PAGE_W)
  ) addr_i (
    .seg       (seg_q),
    .base      (base_q),
    .unpaged   (unpaged_q),
    .frame     (frame),
    .ptw_addr  (ptw_addr),
    .desc_addr (desc_addr)
  );

  sdf_ctl #(
    .SEG_W (SEG_W), .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .FRAME_W (FRAME_W), .DF_BASE (DF_BASE)
  ) ctl_i (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (start),
    .cam_hit    (cam_hit),
    .bypass     (bypass),
    .seg_in     (seg_num),
    .base_in    (dbr_base),
    .unpaged_in (dbr_unpaged),
    .ptw_addr   (ptw_addr),
    .desc_addr  (desc_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .seg_q      (seg_q),
    .base_q     (base_q),
    .unpaged_q  (unpaged_q),
    .bypass_q   (ld_bypass),
    .frame      (frame),
    .w0_q       (ld_word0),
    .w1_q       (ld_word1),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .fault_num  (fault_num)
  );

  assign ld_valid = done;
  assign ld_seg   = seg_q;
endmodule

// File: rtl/sdf_fetch_chk.sv
module sdf_fetch_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 36,
  parameter logic [4:0] DF_BASE = 5'd16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cam_hit,
  input logic              bypass,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              ld_valid,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [4:0]        fault_num
);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && (!cam_hit || bypass))) |=> !busy);

  // R11
  req_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R13
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R4
  wb_used_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[4]);

  // R10
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  // R3
  fault_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_num >= DF_BASE && fault_num <= DF_BASE + 5'd7));

  // R9
  load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (done && !fault && !mem_req));
endmodule

bind seg_desc_fetch sdf_fetch_chk #(
  .ADDR_W (ADDR_W), .DATA_W (DATA_W), .DF_BASE (DF_BASE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cam_hit   (cam_hit),
  .bypass    (bypass),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .ld_valid  (ld_valid),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .fault_num (fault_num)
);

// File: tb/seg_desc_fetch_tb_top.sv
`timescale 1ns/1ps
module seg_desc_fetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [14:0] seg_num = '0;
  logic        cam_hit = 1'b0;
  logic        bypass = 1'b0;
  logic        dbr_unpaged = 1'b0;
  logic [23:0] dbr_base = '0;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [35:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [35:0] mem_rdata = '0;
  logic        ld_valid, ld_bypass, busy, done, fault;
  logic [14:0] ld_seg;
  logic [35:0] ld_word0, ld_word1;
  logic [4:0]  fault_num;

  always #5 clk = ~clk;

  seg_desc_fetch dut_i (
    .clk (clk), .rst_n (rst_n), .start (start), .seg_num (seg_num),
    .cam_hit (cam_hit), .bypass (bypass), .dbr_unpaged (dbr_unpaged),
    .dbr_base (dbr_base), .mem_req (mem_req), .mem_we (mem_we),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_ack (mem_ack),
    .mem_rdata (mem_rdata), .ld_valid (ld_valid), .ld_seg (ld_seg),
    .ld_word0 (ld_word0), .ld_word1 (ld_word1), .ld_bypass (ld_bypass),
    .busy (busy), .done (done), .fault (fault), .fault_num (fault_num)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int wait_cfg = 0;

  logic [35:0] mem [logic [23:0]];
  logic [23:0] a_addr [8];
  bit          a_we [8];
  logic [35:0] a_wdata [8];
  int          a_start [8], a_ack [8];
  int          acc_n = 0;
  bit          in_hs = 0;
  logic [23:0] hs_addr;
  int          hs_start = 0, waited = 0, hold_err = 0;
  int          f_cnt = 0, ld_cnt = 0, busy_cnt = 0, done_cnt = 0;
  logic [4:0]  f_num;
  logic [14:0] c_seg;
  logic [35:0] c_w0, c_w1;
  logic        c_byp;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and output monitor, both on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mem_ack = 1'b0;
      in_hs = 0;
    end else if (mem_req) begin
      if (!in_hs) begin
        in_hs = 1; hs_addr = mem_addr; hs_start = cyc; waited = 0;
      end else if (mem_addr != hs_addr) hold_err++;
      if (waited >= wait_cfg) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 36'h0;
        if (acc_n < 8) begin
          a_addr[acc_n] = mem_addr; a_we[acc_n] = mem_we;
          a_wdata[acc_n] = mem_wdata; a_start[acc_n] = hs_start;
          a_ack[acc_n] = cyc;
        end
        acc_n++;
        in_hs = 0;
      end else begin
        mem_ack = 1'b0;
        waited++;
      end
    end else mem_ack = 1'b0;
    if (fault) begin f_cnt++; f_num = fault_num; end
    if (ld_valid) begin
      ld_cnt++; c_seg = ld_seg; c_w0 = ld_word0; c_w1 = ld_word1; c_byp = ld_bypass;
    end
    if (busy) busy_cnt++;
    if (done) done_cnt++;
  end

  task automatic run(input logic [14:0] s, input logic [23:0] b, input bit unp,
                     input bit hit, input bit byp, input int ws);
    @(posedge clk);
    acc_n = 0; f_cnt = 0; ld_cnt = 0; busy_cnt = 0; done_cnt = 0; hold_err = 0;
    wait_cfg = ws;
    @(negedge clk);
    seg_num = s; dbr_base = b; dbr_unpaged = unp; cam_hit = hit; bypass = byp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seg_num = 15'h7fff; dbr_base = 24'hffffff; bypass = 1'b0; cam_hit = 1'b0;
    for (int k = 0; k < 400 && busy; k++) @(negedge clk);
    chk(!busy, "R11 walk ends idle", busy, 0);
    @(posedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && !mem_req && !done && !fault && !ld_valid, "R11 reset state",
        {busy, mem_req, done, fault, ld_valid}, 0);
    chk(fault_num == 0, "R10 fault_num zero at rest", fault_num, 0);
  endtask

  task automatic t_hit_no_bypass;
    run(15'd9, 24'h1000, 1'b1, 1'b1, 1'b0, 0);
    chk(acc_n == 0 && busy_cnt == 0, "R1 hit without bypass stays idle", acc_n, 0);
    chk(ld_cnt == 0 && f_cnt == 0, "R1 no load or fault on hit", ld_cnt + f_cnt, 0);
  endtask

  task automatic t_unpaged_ok;
    mem[24'h100A] = 36'h0_ABCD_0008;
    mem[24'h100B] = 36'h9_8765_4321;
    run(15'd5, 24'h1000, 1'b1, 1'b0, 1'b0, 0);
    chk(acc_n == 2 && !a_we[0] && !a_we[1], "R6 two reads only", acc_n, 2);
    chk(a_addr[0] == 24'h100A && a_addr[1] == 24'h100B, "R6 unpaged addresses",
        {a_addr[0], a_addr[1]}, {24'h100A, 24'h100B});
    chk(a_start[1] == a_ack[0] + 1, "R7 back-to-back reads", a_start[1], a_ack[0] + 1);
    chk(ld_cnt == 1 && done_cnt == 1 && f_cnt == 0, "R9 single load", ld_cnt, 1);
    chk(c_seg == 15'd5 && c_w0 == 36'h0_ABCD_0008 && c_w1 == 36'h9_8765_4321 && !c_byp,
        "R9 load contents", c_w1, 36'h9_8765_4321);
  endtask

  task automatic t_bypass_hit;
    mem[24'h100C] = 36'h0_0000_00F8;
    mem[24'h100D] = 36'h1_1111_1111;
    run(15'd6, 24'h1000, 1'b1, 1'b1, 1'b1, 0);
    chk(acc_n == 2 && a_addr[0] == 24'h100C, "R1 bypass forces walk", a_addr[0], 24'h100C);
    chk(ld_cnt == 1 && c_byp && c_seg == 15'd6, "R9 bypass flag passed on", c_byp, 1);
  endtask

  task automatic t_paged_used_clear;
    mem[24'h2001] = (36'h55 << 22) | 36'h8;
    mem[24'h15402] = 36'h1_2345_6789;
    mem[24'h15403] = 36'h5_5555_5555;
    run(15'h201, 24'h2000, 1'b0, 1'b0, 1'b0, 0);
    chk(acc_n == 4, "R4 four accesses", acc_n, 4);
    chk(a_addr[0] == 24'h2001 && !a_we[0], "R2 entry read address", a_addr[0], 24'h2001);
    chk(a_we[1] && a_addr[1] == 24'h2001 && a_wdata[1] == ((36'h55 << 22) | 36'h18),
        "R4 used-bit writeback", a_wdata[1], (36'h55 << 22) | 36'h18);
    chk(a_addr[2] == 24'h15402 && a_addr[3] == 24'h15403 && !a_we[2] && !a_we[3],
        "R5 paged descriptor addresses", a_addr[2], 24'h15402);
    chk(ld_cnt == 1 && c_w0 == 36'h1_2345_6789 && c_w1 == 36'h5_5555_5555,
        "R9 paged load", c_w0, 36'h1_2345_6789);
  endtask

  task automatic t_paged_wait;
    mem[24'h3000] = (36'h7 << 22) | 36'h18;
    mem[24'h1C06] = 36'h0_0000_0009;
    mem[24'h1C07] = 36'h0_0000_0077;
    run(15'd3, 24'h3000, 1'b0, 1'b0, 1'b0, 2);
    chk(acc_n == 3 && !a_we[0] && !a_we[1] && !a_we[2], "R4 no write when used set",
        acc_n, 3);
    chk(a_addr[1] == 24'h1C06 && a_addr[2] == 24'h1C07, "R5 addresses with waits",
        a_addr[1], 24'h1C06);
    chk(hold_err == 0 && a_ack[0] - a_start[0] == 2, "R13 request held while waiting",
        hold_err, 0);
    chk(a_start[2] == a_ack[1] + 1, "R7 back-to-back with waits", a_start[2], a_ack[1] + 1);
    chk(ld_cnt == 1 && c_w1 == 36'h77, "R9 load after waits", c_w1, 36'h77);
  endtask

  task automatic t_ptw_fault;
    mem[24'h4000] = 36'h15;
    run(15'd0, 24'h4000, 1'b0, 1'b0, 1'b0, 0);
    chk(acc_n == 1 && ld_cnt == 0, "R3 stop after absent entry", acc_n, 1);
    chk(f_cnt == 1 && f_num == 5'd21, "R3 fault number", f_num, 21);
    chk(done_cnt == 0, "R10 no done with fault", done_cnt, 0);
  endtask

  task automatic t_ptw_fault_used_clear;
    mem[24'h4100] = 36'h02;
    run(15'd0, 24'h4100, 1'b0, 1'b0, 1'b0, 0);
    chk(acc_n == 1 && !a_we[0], "R12 no writeback on absent entry", acc_n, 1);
    chk(f_cnt == 1 && f_num == 5'd18, "R12 fault wins", f_num, 18);
    chk(mem[24'h4100] == 36'h02, "R12 entry unchanged", mem[24'h4100], 36'h02);
  endtask

  task automatic t_sdw_fault;
    mem[24'h5002] = 36'h7;
    mem[24'h5003] = 36'h1;
    run(15'd1, 24'h5000, 1'b1, 1'b0, 1'b0, 0);
    chk(acc_n == 2 && ld_cnt == 0, "R8 no load on absent descriptor", ld_cnt, 0);
    chk(f_cnt == 1 && f_num == 5'd23, "R8 fault number", f_num, 23);
    chk(f_cnt == 1, "R10 single-cycle fault", f_cnt, 1);
  endtask

  task automatic t_reset_mid;
    @(posedge clk);
    wait_cfg = 50;
    @(negedge clk);
    seg_num = 15'd2; dbr_base = 24'h6000; dbr_unpaged = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(mem_req && busy, "R11 walk in progress before reset", mem_req, 1);
    rst_n = 1'b0;
    #1;
    chk(!mem_req && !busy, "R11 reset mid-walk", {mem_req, busy}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wait_cfg = 0;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_req, "R11 idle after release", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hit_no_bypass();
    t_unpaged_ok();
    t_bypass_hit();
    t_paged_used_clear();
    t_paged_wait();
    t_ptw_fault();
    t_ptw_fault_used_clear();
    t_sdw_fault();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule